// File: doc/BRIEF.md
# Self-Timed Successive-Approximation Loop Controller

This block sequences the final 7-bit stage of a converter through a binary search. The search is paced by the comparator's own completion handshake, not by a per-bit clock. The sample phase and the conversion phase do not overlap. When the sample phase ends, the controller raises the comparator strobe. Each completion pulse from the comparator carries one decision. The controller writes that decision into the result at the current bit position, most significant bit first, and drops the strobe. It then raises the strobe again for the next bit. After the seventh decision it sets a done flag and keeps the strobe low until the next sample phase ends.

A neighbouring flash stage samples a shared reference, and capacitor-array switching must stay out of that window. For this purpose a pause request opens a hold window whose length, 1 to 4 cycles of the fast timing clock, comes from a 2-bit code. While the window is open the strobe cannot be raised again, so the search halts between bits. The trial word drives the capacitor array.

Top module: `sar_loop_ctrl`

## Requirements
- R1: After reset the strobe `cmp_clk_o` is low, `done_o` is low and `result_o` is zero.
- R2: The controller detects a start at the first clock edge where `sample_i` is low and was high at the previous edge. With no pause the strobe rises at the edge after that.
- R3: The strobe stays high until a completion pulse (`cmp_valid_i` high at a clock edge while the strobe is high). That edge records `cmp_dec_i` and drops the strobe. If bits remain, the strobe rises again one edge later.
- R4: Exactly 7 strobe pulses occur per conversion. The edge that records the 7th decision sets `done_o`. The strobe then stays low, and `done_o` stays high, until the next start, which clears `done_o`.
- R5: Decisions fill the result from bit 6 down to bit 0. A decision of 1 means the held input is at or above the trial word, and it keeps the trial bit. After a full conversion `result_o` equals the input code.
- R6: While a bit is being decided, `dac_bits_o` holds the decided upper bits, a 1 at the current position and zeros below it. After the last decision `dac_bits_o` equals `result_o`.
- R7: A `pause_start_i` pulse with code c keeps the strobe from rising at that edge and the next c+1 edges. Pausing at a start therefore delays the first strobe rise to c+2 edges after the start edge. Pausing with the completion pulse stretches the strobe-low gap from 1 edge to c+2 edges.
- R8: `sample_i` high aborts any conversion. The strobe is low at the next edge and stays low while `sample_i` is high.
- R9: A completion pulse while the strobe is low is ignored, and `result_o` and the strobe are unchanged.
- R10: A pause, at the start or between bits, has no effect on the final result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | High during the sample phase; its fall starts conversion |
| pause_start_i | input | 1 | One-cycle request opening a hold window |
| pause_code_i | input | 2 | Hold length select, window = code+1 cycles |
| cmp_valid_i | input | 1 | Comparator completion pulse |
| cmp_dec_i | input | 1 | Comparator decision, 1 = input at or above trial |
| cmp_clk_o | output | 1 | Comparator strobe |
| dac_bits_o | output | 7 | Trial word to the capacitor array |
| result_o | output | 7 | Decided bits, MSB first |
| done_o | output | 1 | All 7 decisions taken |

## Verification
A wrong bit index or a lost decision shows within one conversion. Either `result_o` differs from the input held by the comparator model, or the trial word at some strobe rise breaks the decided-bits-plus-one pattern, and this is visible at the very strobe where it goes astray. A miscounted pause window, or a strobe left high or low, appears as a wrong gap measured in edges between the completion pulse and the next strobe rise. A stuck state surfaces as a count other than seven strobe pulses, or as no `done_o`.

// File: rtl/sar_loop_pkg.sv
package sar_loop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_WAIT = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_pause_timer.sv
module sar_pause_timer #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              hold_o
);
  localparam int CNT_W = CODE_W + 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start_i)
      cnt_q <= {1'b0, code_i} + CNT_W'(1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign hold_o = start_i | (cnt_q != '0);

  assert_window_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == {1'b0, $past(code_i)} + CNT_W'(1)));

  assert_window_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int NBITS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             take_i,
  input  logic             dec_i,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] result_o,
  output logic             last_o
);
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NBITS - 1);

  logic [NBITS-1:0] trial_q;
  logic [NBITS-1:0] result_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q  <= '0;
      result_q <= '0;
      idx_q    <= TOP_IDX;
    end else if (init_i) begin
      trial_q  <= '0;
      trial_q[NBITS-1] <= 1'b1;
      result_q <= '0;
      idx_q    <= TOP_IDX;
    end else if (take_i) begin
      result_q[idx_q] <= dec_i;
      trial_q[idx_q]  <= dec_i;
      if (idx_q != '0) begin
        trial_q[idx_q - IDX_W'(1)] <= 1'b1;
        idx_q <= idx_q - IDX_W'(1);
      end
    end
  end

  assign trial_o  = trial_q;
  assign result_o = result_q;
  assign last_o   = (idx_q == '0);

  assert_one_trial_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i || (take_i && !last_o)) |=> ($countones(trial_o ^ result_o) == 1));

  assert_final_trial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !init_i && last_o) |=> (trial_o == result_o));
endmodule

// File: rtl/sar_handshake_fsm.sv
module sar_handshake_fsm
  import sar_loop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  input  logic valid_i,
  input  logic hold_i,
  input  logic last_i,
  output logic cmp_clk_o,
  output logic done_o,
  output logic init_o,
  output logic take_o
);
  sar_state_e state_q;
  logic       sample_q;
  logic       strobe_q;
  logic       done_q;

  assign init_o = sample_q & ~sample_i;
  assign take_o = (state_q == ST_WAIT) & valid_i & ~sample_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sample_q <= 1'b0;
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      sample_q <= sample_i;
      if (sample_i) begin
        state_q  <= ST_IDLE;
        strobe_q <= 1'b0;
      end else if (init_o) begin
        state_q  <= ST_ARM;
        strobe_q <= 1'b0;
        done_q   <= 1'b0;
      end else begin
        case (state_q)
          ST_ARM: if (!hold_i) begin
            state_q  <= ST_WAIT;
            strobe_q <= 1'b1;
          end
          ST_WAIT: if (valid_i) begin
            strobe_q <= 1'b0;
            if (last_i) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_ARM;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cmp_clk_o = strobe_q;
  assign done_o    = done_q;

  assert_sample_kills_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> !cmp_clk_o);

  assert_strobe_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clk_o && !valid_i && !sample_i) |=> cmp_clk_o);

  assert_no_rise_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_clk_o) |-> !$past(hold_i));

  assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmp_clk_o);

  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(valid_i && last_i && cmp_clk_o));
endmodule

// File: rtl/sar_loop_ctrl.sv
module sar_loop_ctrl #(
  parameter int NBITS  = 7,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              pause_start_i,
  input  logic [CODE_W-1:0] pause_code_i,
  input  logic              cmp_valid_i,
  input  logic              cmp_dec_i,
  output logic              cmp_clk_o,
  output logic [NBITS-1:0]  dac_bits_o,
  output logic [NBITS-1:0]  result_o,
  output logic              done_o
);
  logic hold_w;
  logic last_w;
  logic init_w;
  logic take_w;

  sar_pause_timer #(.CODE_W(CODE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (pause_start_i),
    .code_i  (pause_code_i),
    .hold_o  (hold_w)
  );

  sar_handshake_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (sample_i),
    .valid_i   (cmp_valid_i),
    .hold_i    (hold_w),
    .last_i    (last_w),
    .cmp_clk_o (cmp_clk_o),
    .done_o    (done_o),
    .init_o    (init_w),
    .take_o    (take_w)
  );

  sar_bit_reg #(.NBITS(NBITS)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (init_w),
    .take_i   (take_w),
    .dec_i    (cmp_dec_i),
    .trial_o  (dac_bits_o),
    .result_o (result_o),
    .last_o   (last_w)
  );

  assert_stray_valid_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_i && !cmp_clk_o && !init_w) |=> $stable(result_o));
endmodule

// File: tb/sar_loop_ctrl_tb.sv
module sar_loop_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_i = 1'b1;
  logic pause_a = 1'b0;
  logic pause_b = 1'b0;
  logic [1:0] pause_code_i = 2'd0;
  logic model_v = 1'b0, model_d = 1'b0;
  logic spur_v = 1'b0, spur_d = 1'b0;
  logic cmp_clk_o, done_o;
  logic [6:0] dac_bits_o, result_o;

  wire pause_start_i = pause_a | pause_b;
  wire cmp_valid_i   = model_v | spur_v;
  wire cmp_dec_i     = spur_v ? spur_d : model_d;

  int checks = 0, errors = 0, cycles = 0;
  int vin = 0, lat = 1, ncmp = 0, mid_code = 0;
  bit mid_pause = 1'b0;

  always #10 clk = ~clk;

  sar_loop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
    .pause_start_i(pause_start_i), .pause_code_i(pause_code_i),
    .cmp_valid_i(cmp_valid_i), .cmp_dec_i(cmp_dec_i),
    .cmp_clk_o(cmp_clk_o), .dac_bits_o(dac_bits_o),
    .result_o(result_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Comparator and capacitor-array model
  bit prev_clk = 1'b0, busy = 1'b0, gapon = 1'b0;
  int cnt = 0, gap = 0, exp_gap = 2;
  always @(negedge clk) begin
    model_v = 1'b0;
    pause_b = 1'b0;
    if (sample_i) gapon = 1'b0;
    if (gapon) gap++;
    if (cmp_clk_o && !prev_clk) begin
      int pos, expd;
      if (gapon) chk(gap == exp_gap, "R3/R7 strobe gap", gap, exp_gap);
      gapon = 1'b0;
      ncmp++;
      pos  = 7 - ncmp;
      if (pos < 0) pos = 0;
      expd = ((vin >> (pos + 1)) << (pos + 1)) | (1 << pos);
      chk(dac_bits_o == 7'(expd), "R6 trial word", dac_bits_o, expd);
      busy = 1'b1;
      cnt  = lat;
    end
    prev_clk = cmp_clk_o;
    if (busy) begin
      cnt--;
      if (cnt <= 0) begin
        busy    = 1'b0;
        model_v = 1'b1;
        model_d = (vin >= int'(dac_bits_o));
        exp_gap = 2;
        if (mid_pause && ncmp == 3) begin
          pause_b = 1'b1;
          exp_gap = mid_code + 3;
        end
        gapon = (ncmp < 7);
        gap   = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic conv(input int v, input int l, input int code, input bit p_start, input bit p_mid);
    int n, t, low_cnt;
    vin = v; lat = l; mid_pause = p_mid; mid_code = code;
    @(negedge clk);
    sample_i = 1'b1;
    repeat (2) @(negedge clk);
    ncmp = 0;
    pause_code_i = 2'(code);
    sample_i = 1'b0;
    pause_a  = p_start;
    @(negedge clk);
    pause_a = 1'b0;
    chk(!done_o, "R4 done cleared at start", done_o, 0);
    n = 1;
    while (!cmp_clk_o && n < 20) begin @(negedge clk); n++; end
    chk(n == (p_start ? code + 3 : 2), "R2/R7 first strobe delay", n, p_start ? code + 3 : 2);
    t = 0;
    while (!done_o && t < 400) begin @(negedge clk); t++; end
    chk(done_o, "R4 done raised", done_o, 1);
    chk(result_o == 7'(v), (p_start || p_mid) ? "R10 result under pause" : "R5 result", result_o, v);
    chk(ncmp == 7, "R4 seven strobes", ncmp, 7);
    chk(dac_bits_o == result_o, "R6 final trial", dac_bits_o, result_o);
    low_cnt = 0;
    repeat (4) begin @(negedge clk); if (!cmp_clk_o && done_o) low_cnt++; end
    chk(low_cnt == 4, "R4 quiet after done", low_cnt, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmp_clk_o, "R1 strobe low", cmp_clk_o, 0);
    chk(!done_o, "R1 done low", done_o, 0);
    chk(result_o == 0, "R1 result zero", result_o, 0);

    for (int v = 0; v < 128; v++) conv(v, (v % 3) + 1, 0, 1'b0, 1'b0);
    for (int c = 0; c < 4; c++) begin
      conv(37 + c * 20, 2, c, 1'b1, 1'b0);
      conv(127 - c * 31, 1 + c % 3, c, 1'b0, 1'b1);
      conv(64 + c, 3, c, 1'b1, 1'b1);
    end

    // R9: stray completion pulse while idle after a conversion
    conv(0, 1, 0, 1'b0, 1'b0);
    @(negedge clk); spur_v = 1'b1; spur_d = 1'b1;
    @(negedge clk); spur_v = 1'b0; spur_d = 1'b0;
    @(negedge clk);
    chk(result_o == 0, "R9 stray pulse ignored", result_o, 0);
    chk(!cmp_clk_o, "R9 strobe unchanged", cmp_clk_o, 0);

    // R8: abort mid-conversion, late comparator pulse must not land (R9)
    begin
      logic [6:0] held;
      int lows;
      vin = 100; lat = 3; mid_pause = 1'b0;
      @(negedge clk); sample_i = 1'b1;
      repeat (2) @(negedge clk);
      ncmp = 0; sample_i = 1'b0;
      while (ncmp < 2) @(negedge clk);
      sample_i = 1'b1;
      @(negedge clk);
      chk(!cmp_clk_o, "R8 strobe dropped", cmp_clk_o, 0);
      chk(!done_o, "R8 no done", done_o, 0);
      held = result_o;
      lows = 0;
      repeat (6) begin @(negedge clk); if (!cmp_clk_o) lows++; end
      chk(lows == 6, "R8 strobe held low", lows, 6);
      chk(result_o == held, "R9 late pulse ignored", result_o, held);
    end
    conv(85, 2, 1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule